// File: doc/BRIEF.md
# Pin Edge Event and Interrupt Unit

This block watches a wide vector of already-synchronised general-purpose pins, one clock sample at a time, and records transitions on them. It stores one sticky event flag per pin. A flag is set when a pin that is configured as an input makes a transition that is enabled for it: low-to-high when its rise enable is set, or high-to-low when its fall enable is set. Software clears flags by writing ones. The register block in front of this unit turns each such write into a one-cycle pulse that carries a bank index and a 32-bit mask.

The event flags drive three registered interrupt lines. Pins 0 and 1 each have a dedicated line, and a third line is shared by every other pin. There is also a one-cycle wake pulse for a halted processor. It fires when any input pin in a fixed, per-bank set of wake-capable pins changes level. Pins at or above a configured line count have no effect at all.

Top module: `pedge_unit`

## Requirements
- R1: A flag is set when a pin goes from 0 to 1, its rise enable bit is 1 and its direction bit is 0 (input). The flag is visible in `status_o` after the clock edge that samples the new level.
- R2: A flag is set when a pin goes from 1 to 0, its fall enable bit is 1 and its direction bit is 0. A transition whose enable is 0 sets nothing.
- R3: Flags are sticky. A cycle with `clr_valid_i`=1 clears pin `clr_bank_i*32+k` for every bit k that is 1 in `clr_mask_i`, effective at that clock edge. Mask bits that are 0 leave their flags unchanged.
- R4: `irq_pin0_o` and `irq_pin1_o` equal flag bits 0 and 1, delayed by one clock.
- R5: `irq_shared_o` is the OR of all flag bits from 2 upward, delayed by one clock.
- R6: Pins with an index of `ACTIVE_LINES` or more never set a flag and never cause a wake pulse.
- R7: When a set event and a clear hit the same flag in the same cycle, the flag ends up set.
- R8: `wake_o` is high for the clock that follows a sampled cycle in which `halted_i`=1 and some input pin in the wake set changed level. The wake set per bank, from bank 0 to bank 3, is 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F, where bit k stands for pin bank*32+k.
- R9: While `rst_n`=0, all flags, interrupts and the wake output are 0.
- R10: The first sample after reset only loads the level reference, so no flag and no wake pulse can result from it.
- R11: A pin whose direction bit is 1 (output) never sets a flag and never causes a wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | BANKS*32 | Synchronised pin levels |
| rise_en_i | input | BANKS*32 | Per-pin rise enable |
| fall_en_i | input | BANKS*32 | Per-pin fall enable |
| dir_out_i | input | BANKS*32 | Per-pin direction, 1 = output |
| clr_valid_i | input | 1 | Write-one-to-clear pulse |
| clr_bank_i | input | BSEL_W | Bank addressed by the clear |
| clr_mask_i | input | 32 | Bits to clear in that bank |
| halted_i | input | 1 | Processor is halted |
| status_o | output | BANKS*32 | Sticky event flags |
| irq_pin0_o | output | 1 | Interrupt for pin 0 |
| irq_pin1_o | output | 1 | Interrupt for pin 1 |
| irq_shared_o | output | 1 | Interrupt for all other pins |
| wake_o | output | 1 | Wake request pulse |

## Verification
The bench builds the unit with four banks and `ACTIVE_LINES` set to 120. This leaves the top eight pins of bank 3 dead, so the ignore path of R6 is exercised next to live pins in the same word. With all four banks present, every entry of the wake set can be reached, and each bank can be cleared by its own index. A behavioural model is compared with every output on every clock. This covers random toggling, random enable and direction masks, and clear writes that collide with events.

// File: rtl/pedge_pkg.sv
package pedge_pkg;
  localparam int WORD_W = 32;

  // Fixed set of pins allowed to wake a halted processor, per bank.
  function automatic logic [WORD_W-1:0] wake_word(input int bank);
    case (bank)
      0:       wake_word = 32'h8003FE1B;
      1:       wake_word = 32'h002001FC;
      2:       wake_word = 32'hEC080000;
      3:       wake_word = 32'h0012007F;
      default: wake_word = '0;
    endcase
  endfunction

  // Pins of a bank that lie below the active line count.
  function automatic logic [WORD_W-1:0] live_word(input int bank, input int lines);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < WORD_W; i++) w[i] = ((bank * WORD_W + i) < lines);
    return w;
  endfunction

  // Enabled transitions on input pins.
  function automatic logic [WORD_W-1:0] edge_events(
      input logic [WORD_W-1:0] prev, input logic [WORD_W-1:0] cur,
      input logic [WORD_W-1:0] rise, input logic [WORD_W-1:0] fall,
      input logic [WORD_W-1:0] dir_out, input logic [WORD_W-1:0] live);
    return ((cur & ~prev & rise) | (~cur & prev & fall)) & ~dir_out & live;
  endfunction
endpackage

// File: rtl/pedge_bank.sv
module pedge_bank
  import pedge_pkg::*;
#(
  parameter int BANK_ID      = 0,
  parameter int ACTIVE_LINES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed_i,
  input  logic [WORD_W-1:0] pin_i,
  input  logic [WORD_W-1:0] rise_i,
  input  logic [WORD_W-1:0] fall_i,
  input  logic [WORD_W-1:0] dir_i,
  input  logic              clr_hit_i,
  input  logic [WORD_W-1:0] clr_mask_i,
  output logic [WORD_W-1:0] status_o,
  output logic              wake_hit_o
);
  localparam logic [WORD_W-1:0] LIVE = live_word(BANK_ID, ACTIVE_LINES);
  localparam logic [WORD_W-1:0] WAKE = wake_word(BANK_ID);

  logic [WORD_W-1:0] prev_q, st_q;
  logic [WORD_W-1:0] set_evt, clr_bits, changed;

  assign set_evt  = armed_i ? edge_events(prev_q, pin_i, rise_i, fall_i, dir_i, LIVE) : '0;
  assign clr_bits = clr_hit_i ? clr_mask_i : '0;
  assign changed  = (pin_i ^ prev_q) & ~dir_i & LIVE;
  assign wake_hit_o = armed_i && ((changed & WAKE) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      st_q   <= '0;
    end else begin
      prev_q <= pin_i;
      st_q   <= (st_q & ~clr_bits) | set_evt;
    end
  end

  assign status_o = st_q;

  // R7: an event wins over a simultaneous clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((st_q & $past(set_evt)) == $past(set_evt)));

  // R3: a flag only drops when its clear bit was written
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(st_q) & ~st_q & ~$past(clr_bits)) == '0));

  // R6: dead pins never hold a flag
  a_r6_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q & ~LIVE) == '0);

  // R11: a flag never appears on a pin that was an output
  a_r11_outputs_silent: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st_q & ~$past(st_q) & $past(dir_i)) == '0));
endmodule

// File: rtl/pedge_irq_merge.sv
module pedge_irq_merge #(
  parameter int PINS = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] status_i,
  output logic            irq0_o,
  output logic            irq1_o,
  output logic            irqx_o
);
  logic any_rest;
  assign any_rest = |status_i[PINS-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_o <= 1'b0;
      irq1_o <= 1'b0;
      irqx_o <= 1'b0;
    end else begin
      irq0_o <= status_i[0];
      irq1_o <= status_i[1];
      irqx_o <= any_rest;
    end
  end

  // R4: dedicated lines trail their flags by one clock
  a_r4_line0_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq0_o == $past(status_i[0])));
  a_r4_line1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq1_o == $past(status_i[1])));
  // R5: shared line drops only once all upper flags were clear
  a_r5_shared_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqx_o) |-> ($past(status_i[PINS-1:2]) == '0));
endmodule

// File: rtl/pedge_unit.sv
module pedge_unit
  import pedge_pkg::*;
#(
  parameter int BANKS        = 4,
  parameter int ACTIVE_LINES = 128,
  localparam int PINS        = BANKS * WORD_W,
  localparam int BSEL_W      = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_i,
  input  logic [PINS-1:0]   rise_en_i,
  input  logic [PINS-1:0]   fall_en_i,
  input  logic [PINS-1:0]   dir_out_i,
  input  logic              clr_valid_i,
  input  logic [BSEL_W-1:0] clr_bank_i,
  input  logic [WORD_W-1:0] clr_mask_i,
  input  logic              halted_i,
  output logic [PINS-1:0]   status_o,
  output logic              irq_pin0_o,
  output logic              irq_pin1_o,
  output logic              irq_shared_o,
  output logic              wake_o
);
  logic             armed_q, wake_q;
  logic [BANKS-1:0] clr_sel, wake_hit;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign clr_sel[b] = clr_valid_i && (clr_bank_i == BSEL_W'(b));
    pedge_bank #(.BANK_ID(b), .ACTIVE_LINES(ACTIVE_LINES)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed_i   (armed_q),
      .pin_i     (pin_i[b*WORD_W +: WORD_W]),
      .rise_i    (rise_en_i[b*WORD_W +: WORD_W]),
      .fall_i    (fall_en_i[b*WORD_W +: WORD_W]),
      .dir_i     (dir_out_i[b*WORD_W +: WORD_W]),
      .clr_hit_i (clr_sel[b]),
      .clr_mask_i(clr_mask_i),
      .status_o  (status_o[b*WORD_W +: WORD_W]),
      .wake_hit_o(wake_hit[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      wake_q  <= halted_i && (wake_hit != '0);
    end
  end

  assign wake_o = wake_q;

  pedge_irq_merge #(.PINS(PINS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .status_i(status_o),
    .irq0_o  (irq_pin0_o),
    .irq1_o  (irq_pin1_o),
    .irqx_o  (irq_shared_o)
  );

  // R8: a wake pulse requires the processor to have been halted
  a_r8_wake_needs_halt: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(halted_i));
  // R10: the reference-loading sample raises nothing
  a_r10_first_sample_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> ((status_o == '0) && !wake_q));
endmodule

// File: tb/pedge_unit_tb_top.sv
`timescale 1ns/1ps
module pedge_unit_tb_top;
  localparam int BANKS = 4;
  localparam int LINES = 120;
  localparam int PINS  = BANKS * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PINS-1:0] pins = '0, rise = '0, fall = '0, dir = '0;
  logic clr_v = 1'b0;
  logic [1:0] clr_bank = '0;
  logic [31:0] clr_mask = '0;
  logic halted = 1'b0;
  logic [PINS-1:0] status;
  logic irq0, irq1, irqx, wake;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pedge_unit #(.BANKS(BANKS), .ACTIVE_LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .rise_en_i(rise), .fall_en_i(fall),
    .dir_out_i(dir), .clr_valid_i(clr_v), .clr_bank_i(clr_bank), .clr_mask_i(clr_mask),
    .halted_i(halted), .status_o(status), .irq_pin0_o(irq0), .irq_pin1_o(irq1),
    .irq_shared_o(irqx), .wake_o(wake));

  // behavioural reference state
  logic [PINS-1:0] m_prev = '0, m_status = '0;
  bit m_armed = 0, m_irq0 = 0, m_irq1 = 0, m_irqx = 0, m_wake = 0;

  function automatic bit wake_pin(int p);
    logic [31:0] w;
    w = (p < 32) ? 32'h8003FE1B : (p < 64) ? 32'h002001FC :
        (p < 96) ? 32'hEC080000 : 32'h0012007F;
    return w[p % 32];
  endfunction

  task automatic check(input string tag, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [PINS-1:0] nxt;
    bit w;
    if (!rst_n) begin
      m_prev = '0; m_status = '0; m_armed = 0;
      m_irq0 = 0; m_irq1 = 0; m_irqx = 0; m_wake = 0;
    end else begin
      m_irq0 = m_status[0];
      m_irq1 = m_status[1];
      m_irqx = (m_status >> 2) != '0;
      nxt = m_status;
      w = 0;
      for (int p = 0; p < PINS; p++) begin
        if (clr_v && (int'(clr_bank) == p / 32) && clr_mask[p % 32]) nxt[p] = 1'b0;
        if (m_armed && p < LINES && !dir[p]) begin
          if (pins[p] && !m_prev[p] && rise[p]) nxt[p] = 1'b1;
          if (!pins[p] && m_prev[p] && fall[p]) nxt[p] = 1'b1;
          if (halted && (pins[p] != m_prev[p]) && wake_pin(p)) w = 1;
        end
      end
      m_wake = w;
      m_status = nxt;
      m_prev = pins;
      m_armed = 1;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check("R1/R2/R3 status vs model", status, m_status);
    check("R4 irq_pin0 vs model", PINS'(irq0), PINS'(m_irq0));
    check("R4 irq_pin1 vs model", PINS'(irq1), PINS'(m_irq1));
    check("R5 irq_shared vs model", PINS'(irqx), PINS'(m_irqx));
    check("R8 wake vs model", PINS'(wake), PINS'(m_wake));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    check("R9 reset flags", status, '0);
    check("R9 reset outputs", PINS'({irq0, irq1, irqx, wake}), '0);

    rst_n = 1'b1; pins = '1; rise = '1; fall = '1; dir = '0;
    tick();
    check("R10 first sample quiet", status, '0);

    pins[5] = 1'b0; tick();
    check("R2 fall flag pin5", PINS'(status[5]), 1);
    check("R5 shared not yet", PINS'(irqx), 0);
    tick();
    check("R5 shared one clock later", PINS'(irqx), 1);

    fall[0] = 1'b0; pins[0] = 1'b0; tick();
    check("R2 disabled fall ignored", PINS'(status[0]), 0);
    pins[0] = 1'b1; tick();
    check("R1 rise flag pin0", PINS'(status[0]), 1);
    check("R4 irq0 not yet", PINS'(irq0), 0);
    tick();
    check("R4 irq0 after one clock", PINS'(irq0), 1);

    pins[125] = 1'b0; tick();
    check("R6 dead pin ignored", PINS'(status[125]), 0);

    dir[40] = 1'b1; pins[40] = 1'b0; tick();
    check("R11 output pin ignored", PINS'(status[40]), 0);
    dir[40] = 1'b0;

    pins[7] = 1'b0; clr_v = 1'b1; clr_bank = 2'd0; clr_mask = 32'h80; tick();
    check("R7 set wins over clear", PINS'(status[7]), 1);

    clr_mask = 32'h20; tick();
    clr_v = 1'b0;
    check("R3 one clears", PINS'(status[5]), 0);
    check("R3 zero keeps", PINS'(status[7]), 1);

    halted = 1'b1; pins[3] = 1'b0; tick();
    check("R8 wake on wake pin", PINS'(wake), 1);
    pins[2] = 1'b0; tick();
    check("R8 no wake on other pin", PINS'(wake), 0);
    halted = 1'b0; pins[3] = 1'b1; tick();
    check("R8 no wake when running", PINS'(wake), 0);

    for (int c = 0; c < 3000; c++) begin
      if (c % 200 == 0) begin
        rise = {$urandom, $urandom, $urandom, $urandom};
        fall = {$urandom, $urandom, $urandom, $urandom};
        dir  = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
        halted = $urandom % 2;
      end
      for (int b = 0; b < BANKS; b++)
        pins[b*32 +: 32] ^= $urandom & $urandom & $urandom;
      clr_v = ($urandom % 4) == 0;
      clr_bank = 2'($urandom);
      clr_mask = $urandom;
      if (c == 1500) rst_n = 1'b0;
      if (c == 1503) rst_n = 1'b1;
      tick();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule